// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one I2C master transfer at the byte level. A register interface gives it a 7-bit or 10-bit target address, a direction and a payload length. A start command, with an optional stop request, launches the transfer. The block then produces the START condition, the address byte or bytes, and the payload. It finishes with either a STOP or a held bus that a repeated START can continue.

Payload bytes come from a transmit queue and go to a receive queue. Both are reached through valid/ready handshakes. When either side cannot keep pace, the block holds SCL low instead of losing a byte. It watches the lines for START and STOP patterns to keep a bus-busy indication. It samples the target's acknowledge after every byte it sends, and it drives ACK or NACK on every byte it receives.

Top module: `i2c_xfer_master`

## Requirements
- R1: A start command is accepted only while the block is idle and either the bus is not busy or the bus is still held by this block after a transfer that ended without STOP. Otherwise the command has no effect: no SCL or SDA activity follows.
- R2: With 7-bit addressing, the single address byte is the address bits [6:0] followed by the direction bit (1 = read, 0 = write), sent MSB first.
- R3: With 10-bit addressing, the first address byte is 11110, then address bits [9:8], then the direction bit. The second byte is address bits [7:0].
- R4: `count_left` loads the payload length on an accepted start and drops by one at the end of each payload byte. A length of zero produces an address-only transfer.
- R5: If the stop request was set, the transfer ends with a STOP. Otherwise it ends with SCL held low and SDA released, and the bus stays busy so that the next start produces a repeated START.
- R6: `bus_busy` is set one cycle after the sampled lines show SDA falling while SCL is high. It is cleared one cycle after they show SDA rising while SCL is high.
- R7: Each received byte is offered on `rx_data`/`rx_valid`. While a byte is offered and not taken, SCL is held low.
- R8: In a read, the block ACKs (SDA low) every received byte except the last, which it NACKs (SDA released).
- R9: Written payload bytes are taken from the transmit handshake and sent MSB first. If no byte is available while `count_left` is nonzero, SCL is held low and `underflow_flag` is set. The flag stays set until the next accepted start.
- R10: A NACK after an address byte or after a written payload byte sets `nack_flag` and ends the transfer with a STOP, even when no stop was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 10 | Target address |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_read | input | 1 | 1 = read transfer, 0 = write |
| cfg_count | input | CNT_W | Payload byte count |
| cmd_start | input | 1 | One-cycle start command |
| cmd_stop | input | 1 | Stop request, sampled with cmd_start |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_ready | output | 1 | Block takes tx_data this cycle when valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds an untaken byte |
| rx_ready | input | 1 | Consumer takes rx_data |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| bus_busy | output | 1 | Bus in use |
| xfer_active | output | 1 | Transfer in progress |
| nack_flag | output | 1 | Target refused a byte |
| underflow_flag | output | 1 | Transmit data ran out mid-transfer |
| count_left | output | CNT_W | Payload bytes still to go |

## Verification
The assertions assume that `scl_in` and `sda_in` are already synchronous to `clk`. They also assume that the lines settle between clock edges, so each START or STOP pattern appears across two consecutive samples. Finally, they assume that handshake inputs change only away from the active edge. The bench meets these conditions in two ways. It resolves the wired-AND lines from the block's pull-downs plus a target model that updates only on the falling clock edge. It drives commands, the receive gate and any foreign bus activity a fixed delay after the rising edge.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_DATA,
    ST_STOP
  } seq_state_t;

  localparam logic [4:0] TEN_BIT_MARK = 5'b11110;
endpackage

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
  parameter int QUARTER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) cnt_d = '0;
    else if (cnt_q == TW'(QUARTER - 1)) cnt_d = '0;
    else cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == TW'(QUARTER - 1));
endmodule

// File: rtl/i2c_line_watch.sv
module i2c_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_p, sda_p, busy_q, busy_d;
  logic saw_start, saw_stop;

  assign saw_start = scl_p && scl_in && sda_p && !sda_in;
  assign saw_stop  = scl_p && scl_in && !sda_p && sda_in;

  always_comb begin
    busy_d = busy_q;
    if (saw_start) busy_d = 1'b1;
    else if (saw_stop) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_p  <= scl_in;
      sda_p  <= sda_in;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R6: busy only rises right after a START pattern on the lines
  a_r6_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(scl_in && sda_p && !sda_in));
  // R6: busy only falls right after a STOP pattern on the lines
  a_r6_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(scl_in && !sda_p && sda_in));
endmodule

// File: rtl/i2c_xfer_master.sv
module i2c_xfer_master
  import i2c_seq_pkg::*;
#(
  parameter int QUARTER = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [9:0]       cfg_addr,
  input  logic             cfg_ten_bit,
  input  logic             cfg_read,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             bus_busy,
  output logic             xfer_active,
  output logic             nack_flag,
  output logic             underflow_flag,
  output logic [CNT_W-1:0] count_left
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  seq_state_t       state_q, state_d;
  logic [1:0]       ph_q, ph_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, alo_q, alo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic rd_q, rd_d, stp_q, stp_d, ten_q, ten_d, own_q, own_d;
  logic need_q, need_d, rxv_q, rxv_d, nack_q, nack_d, udf_q, udf_d;
  logic ackin_q, ackin_d;
  logic tick, hold, step, scl_c, sda_c, rx_mode, busy_w, go;
  logic [7:0] first_byte;

  i2c_quarter_timer #(.QUARTER(QUARTER)) u_timer (
    .clk(clk), .rst_n(rst_q), .run(state_q != ST_IDLE), .tick(tick));

  i2c_line_watch u_watch (
    .clk(clk), .rst_n(rst_q), .scl_in(scl_in), .sda_in(sda_in), .busy(busy_w));

  assign rx_mode    = (state_q == ST_DATA) && rd_q;
  assign first_byte = cfg_ten_bit ? {TEN_BIT_MARK, cfg_addr[9:8], cfg_read}
                                  : {cfg_addr[6:0], cfg_read};
  assign go = (state_q == ST_IDLE) && cmd_start && (!busy_w || own_q);

  // line drive per state and quarter phase
  always_comb begin
    scl_c = 1'b0;
    sda_c = 1'b0;
    case (state_q)
      ST_IDLE:  scl_c = own_q;
      ST_START: begin
        scl_c = (ph_q == 2'd0) ? own_q : (ph_q == 2'd3);
        sda_c = ph_q[1];
      end
      ST_ADDR, ST_DATA: begin
        scl_c = (ph_q == 2'd0) || (ph_q == 2'd3);
        if (bit_q == ACK_SLOT) sda_c = rx_mode && (cnt_q != CNT_W'(1));
        else sda_c = !rx_mode && !sh_q[7];
      end
      ST_STOP: begin
        scl_c = (ph_q == 2'd0);
        sda_c = !ph_q[1];
      end
      default: ;
    endcase
  end

  assign hold = (!scl_c && !scl_in) || need_q ||
                (rx_mode && bit_q == ACK_SLOT && ph_q == 2'd0 && rxv_q);
  assign step = tick && !hold;

  always_comb begin
    state_d = state_q; ph_d = ph_q; bit_d = bit_q; sh_d = sh_q; alo_d = alo_q;
    cnt_d = cnt_q; rd_d = rd_q; stp_d = stp_q; ten_d = ten_q; own_d = own_q;
    need_d = need_q; rxv_d = rxv_q; nack_d = nack_q; udf_d = udf_q;
    ackin_d = ackin_q;
    if (need_q) begin
      if (tx_valid) begin
        sh_d = tx_data;
        need_d = 1'b0;
      end else begin
        udf_d = 1'b1;
      end
    end
    if (rxv_q && rx_ready) rxv_d = 1'b0;
    if (go) begin
      state_d = ST_START; ph_d = 2'd0; bit_d = '0;
      cnt_d = cfg_count; rd_d = cfg_read; stp_d = cmd_stop;
      ten_d = cfg_ten_bit; alo_d = cfg_addr[7:0]; sh_d = first_byte;
      nack_d = 1'b0; udf_d = 1'b0;
    end else if (step) begin
      ph_d = ph_q + 2'd1;
      if (ph_q == 2'd2 && (state_q == ST_ADDR || state_q == ST_DATA)) begin
        if (bit_q == ACK_SLOT) ackin_d = sda_in;
        else if (rx_mode) begin
          sh_d = {sh_q[6:0], sda_in};
          if (bit_q == 4'd7) rxv_d = 1'b1;
        end
      end
      if (ph_q == 2'd3) begin
        case (state_q)
          ST_START: begin
            state_d = ST_ADDR; bit_d = '0; own_d = 1'b1;
          end
          ST_STOP: begin
            state_d = ST_IDLE; own_d = 1'b0;
          end
          ST_ADDR, ST_DATA: begin
            if (bit_q != ACK_SLOT) begin
              bit_d = bit_q + 4'd1;
              if (!rx_mode) sh_d = {sh_q[6:0], 1'b0};
            end else begin
              bit_d = '0;
              if (state_q == ST_ADDR) begin
                if (ackin_q) begin
                  nack_d = 1'b1; state_d = ST_STOP;
                end else if (ten_q) begin
                  ten_d = 1'b0; sh_d = alo_q;
                end else if (cnt_q == '0) begin
                  state_d = stp_q ? ST_STOP : ST_IDLE;
                end else begin
                  state_d = ST_DATA; need_d = !rd_q;
                end
              end else begin
                cnt_d = cnt_q - 1'b1;
                if (!rd_q && ackin_q) begin
                  nack_d = 1'b1; state_d = ST_STOP;
                end else if (cnt_q == CNT_W'(1)) begin
                  state_d = stp_q ? ST_STOP : ST_IDLE;
                end else begin
                  need_d = !rd_q;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE; ph_q <= '0; bit_q <= '0; sh_q <= '0; alo_q <= '0;
      cnt_q <= '0; rd_q <= 1'b0; stp_q <= 1'b0; ten_q <= 1'b0; own_q <= 1'b0;
      need_q <= 1'b0; rxv_q <= 1'b0; nack_q <= 1'b0; udf_q <= 1'b0;
      ackin_q <= 1'b1;
    end else begin
      state_q <= state_d; ph_q <= ph_d; bit_q <= bit_d; sh_q <= sh_d;
      alo_q <= alo_d; cnt_q <= cnt_d; rd_q <= rd_d; stp_q <= stp_d;
      ten_q <= ten_d; own_q <= own_d; need_q <= need_d; rxv_q <= rxv_d;
      nack_q <= nack_d; udf_q <= udf_d; ackin_q <= ackin_d;
    end
  end

  assign scl_oe         = scl_c;
  assign sda_oe         = sda_c;
  assign tx_ready       = need_q;
  assign rx_data        = sh_q;
  assign rx_valid       = rxv_q;
  assign bus_busy       = busy_w;
  assign xfer_active    = (state_q != ST_IDLE);
  assign nack_flag      = nack_q;
  assign underflow_flag = udf_q;
  assign count_left     = cnt_q;

  // R1: a start refused because another master holds the bus leaves the block idle
  a_r1_refuse_busy: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_IDLE && cmd_start && bus_busy && !own_q) |=> !xfer_active);
  // R4: the remaining count never grows during a transfer
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_q)
    (xfer_active && $past(xfer_active) && $past(state_q) != ST_IDLE)
      |-> count_left <= $past(count_left));
  // R7: an untaken received byte keeps SCL pulled low
  a_r7_rx_stall: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_valid && !rx_ready) |-> scl_oe);
  // R9: waiting for transmit data keeps SCL pulled low
  a_r9_tx_stall: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_ready && !tx_valid) |-> scl_oe);
  // R9: underflow only rises while bytes remain
  a_r9_udf_count: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(underflow_flag) |-> count_left != '0);
endmodule

// File: tb/i2c_xfer_master_test.sv
module i2c_xfer_master_test;
  logic clk, rst_n;
  logic [9:0] cfg_addr;
  logic cfg_ten_bit, cfg_read, cmd_start, cmd_stop;
  logic [15:0] cfg_count;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0] rx_data;
  logic scl_oe, sda_oe, bus_busy, xfer_active, nack_flag, underflow_flag;
  logic [15:0] count_left;
  logic ext_sda_low, slv_sda_low;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_sda_low || ext_sda_low);

  i2c_xfer_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_ten_bit(cfg_ten_bit),
    .cfg_read(cfg_read), .cfg_count(cfg_count), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .bus_busy(bus_busy),
    .xfer_active(xfer_active), .nack_flag(nack_flag),
    .underflow_flag(underflow_flag), .count_left(count_left));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit [7:0] wr_log[$], rd_q[$], rx_log[$], tx_q[$];
  bit ack_log[$];
  int stop_cnt = 0, nack_at = -1;
  bit run_model = 0;

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog all actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  // target model, queue feeders and busy reference, all at the falling edge
  bit ps_scl = 1, ps_sda = 1, exp_busy = 0, mack = 0, tx_pend = 0;
  int bitc = 0, mode = 0, nfr = 0;
  bit [7:0] sh = 0, first_b = 0, cur_rd = 0;
  always @(negedge clk) begin
    if (run_model) begin
      bit s, d;
      chk("R6", bus_busy, exp_busy, "busy per-clock");
      if (ps_scl && scl_line && ps_sda && !sda_line) begin
        bitc = 0; nfr = 0; mode = 1; slv_sda_low = 0;
      end else if (ps_scl && scl_line && !ps_sda && sda_line) begin
        stop_cnt++; mode = 0; slv_sda_low = 0;
      end else if (!ps_scl && scl_line) begin
        if (bitc < 8) sh = {sh[6:0], sda_line};
        else begin
          mack = !sda_line;
          if (mode == 3) ack_log.push_back(mack);
        end
        bitc++;
      end else if (ps_scl && !scl_line && mode != 0) begin
        if (bitc == 8) begin
          if (mode != 3) begin
            wr_log.push_back(sh);
            if (nfr == 0) first_b = sh;
            slv_sda_low = (nfr != nack_at);
            nfr++;
          end else slv_sda_low = 0;
        end else if (bitc == 9) begin
          bitc = 0; slv_sda_low = 0;
          if (mode == 1) begin
            if (!(nfr == 1 && first_b[7:3] == 5'b11110))
              mode = first_b[0] ? 3 : 2;
            if (mode == 3 && rd_q.size() > 0) begin
              cur_rd = rd_q.pop_front(); slv_sda_low = !cur_rd[7];
            end
          end else if (mode == 3) begin
            if (mack && rd_q.size() > 0) begin
              cur_rd = rd_q.pop_front(); slv_sda_low = !cur_rd[7];
            end else mode = 0;
          end
        end else if (mode == 3 && bitc >= 1 && bitc <= 7) begin
          slv_sda_low = !cur_rd[7 - bitc];
        end
      end
      ps_scl = scl_line;
      s = !scl_oe;
      d = !(sda_oe || slv_sda_low || ext_sda_low);
      if (ps_scl && s && ps_sda && !d) exp_busy = 1;
      else if (ps_scl && s && !ps_sda && d) exp_busy = 0;
      ps_sda = d;
      if (tx_pend) void'(tx_q.pop_front());
      tx_valid = (tx_q.size() > 0);
      tx_data  = tx_valid ? tx_q[0] : 8'h00;
      tx_pend  = tx_valid && tx_ready;
      if (rx_valid && rx_ready) rx_log.push_back(rx_data);
    end
  end

  task automatic tick_n(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic kick(logic [9:0] a, bit ten, bit rd, int n, bit stp);
    @(posedge clk); #2;
    cfg_addr = a; cfg_ten_bit = ten; cfg_read = rd; cfg_count = 16'(n);
    cmd_stop = stp; cmd_start = 1;
    @(posedge clk); #2;
    cmd_start = 0;
  endtask

  task automatic wait_idle(string req);
    int k = 0;
    while (xfer_active && k < 20000) begin tick_n(1); k++; end
    chk(req, xfer_active, 0, "transfer finished");
  endtask

  task automatic clear_logs();
    wr_log.delete(); rx_log.delete(); ack_log.delete(); nack_at = -1;
  endtask

  task automatic expect_wr(string req, bit [7:0] e[$]);
    chk(req, wr_log.size(), e.size(), "byte count on bus");
    foreach (e[i]) if (i < wr_log.size()) chk(req, wr_log[i], e[i], "bus byte");
  endtask

  initial begin
    int s0, low_bad;
    rst_n = 0; cmd_start = 0; cmd_stop = 0; cfg_addr = 0; cfg_ten_bit = 0;
    cfg_read = 0; cfg_count = 0; tx_valid = 0; tx_data = 0; rx_ready = 1;
    ext_sda_low = 0; slv_sda_low = 0;
    tick_n(4);
    // reset state
    chk("R6", bus_busy, 0, "reset busy");
    chk("R1", xfer_active, 0, "reset active");
    chk("R5", scl_oe | sda_oe, 0, "reset lines released");
    chk("R4", count_left, 0, "reset count");
    rst_n = 1; run_model = 1;
    tick_n(5);

    // R2 R9 R5: 7-bit write, three bytes, with stop
    clear_logs(); s0 = stop_cnt;
    tx_q.push_back(8'hC3); tx_q.push_back(8'h18); tx_q.push_back(8'hE7);
    kick(10'h02A, 0, 0, 3, 1); wait_idle("R2");
    expect_wr("R2", '{8'h54, 8'hC3, 8'h18, 8'hE7});
    chk("R5", stop_cnt - s0, 1, "stop issued");
    chk("R4", count_left, 0, "count after write");
    chk("R10", nack_flag, 0, "no nack on acked write");
    tick_n(3);
    chk("R6", bus_busy, 0, "bus free after stop");

    // R3: 10-bit write, two bytes
    clear_logs();
    tx_q.push_back(8'h01); tx_q.push_back(8'h80);
    kick(10'h2D5, 1, 0, 2, 1); wait_idle("R3");
    expect_wr("R3", '{8'hF4, 8'hD5, 8'h01, 8'h80});

    // R7 R8: read three bytes, receive side stalled on the first
    clear_logs(); rd_q = '{8'hA5, 8'h3C, 8'h7E};
    rx_ready = 0;
    kick(10'h015, 0, 1, 3, 1);
    begin
      int k = 0;
      while (!rx_valid && k < 5000) begin tick_n(1); k++; end
    end
    chk("R7", rx_valid, 1, "first byte offered");
    low_bad = 0;
    for (int i = 0; i < 200; i++) begin
      if (scl_line !== 1'b0) low_bad++;
      tick_n(1);
    end
    chk("R7", low_bad, 0, "SCL high cycles during stall");
    rx_ready = 1;
    wait_idle("R7");
    expect_wr("R2", '{8'h2B});
    chk("R7", rx_log.size(), 3, "received byte count");
    if (rx_log.size() == 3) begin
      chk("R7", rx_log[0], 8'hA5, "rx byte 0");
      chk("R7", rx_log[1], 8'h3C, "rx byte 1");
      chk("R7", rx_log[2], 8'h7E, "rx byte 2");
    end
    chk("R8", ack_log.size(), 3, "ack slots seen");
    if (ack_log.size() == 3) begin
      chk("R8", ack_log[0], 1, "ack byte 0");
      chk("R8", ack_log[1], 1, "ack byte 1");
      chk("R8", ack_log[2], 0, "nack on last byte");
    end

    // R10: target refuses the second payload byte
    clear_logs(); s0 = stop_cnt; tx_q.delete();
    tx_q = '{8'h11, 8'h22, 8'h33, 8'h44};
    nack_at = 2;
    kick(10'h02A, 0, 0, 4, 0); wait_idle("R10");
    chk("R10", nack_flag, 1, "nack flag on data");
    chk("R10", stop_cnt - s0, 1, "stop forced after data nack");
    chk("R4", count_left, 2, "count after data nack");
    tx_q.delete(); tick_n(3);

    // R10: target refuses the address
    clear_logs(); s0 = stop_cnt; nack_at = 0;
    kick(10'h033, 0, 0, 2, 1); wait_idle("R10");
    chk("R10", nack_flag, 1, "nack flag on address");
    chk("R10", wr_log.size(), 1, "only address on bus");
    chk("R4", count_left, 2, "count untouched by address nack");
    chk("R10", stop_cnt - s0, 1, "stop after address nack");

    // R5 R1: write without stop, then repeated start read
    clear_logs(); s0 = stop_cnt; tx_q.push_back(8'h5A);
    kick(10'h02A, 0, 0, 1, 0); wait_idle("R5");
    tick_n(40);
    chk("R5", bus_busy, 1, "bus held after no-stop end");
    chk("R5", scl_line, 0, "SCL held low");
    chk("R5", stop_cnt - s0, 0, "no stop issued");
    rd_q = '{8'h99};
    kick(10'h02A, 0, 1, 1, 1); wait_idle("R1");
    expect_wr("R5", '{8'h54, 8'h5A, 8'h55});
    chk("R1", rx_log.size() > 0 ? rx_log[0] : 0, 8'h99, "byte after repeated start");
    chk("R5", stop_cnt - s0, 1, "stop after repeated start read");

    // R9: transmit data runs out
    clear_logs(); tx_q.push_back(8'hF0);
    kick(10'h02A, 0, 0, 2, 1);
    begin
      int k = 0;
      while (!underflow_flag && k < 5000) begin tick_n(1); k++; end
    end
    chk("R9", underflow_flag, 1, "underflow flagged");
    chk("R9", count_left, 1, "count at underflow");
    low_bad = 0;
    for (int i = 0; i < 100; i++) begin
      if (scl_line !== 1'b0) low_bad++;
      tick_n(1);
    end
    chk("R9", low_bad, 0, "SCL high cycles while starved");
    tx_q.push_back(8'h0F);
    wait_idle("R9");
    expect_wr("R9", '{8'h54, 8'hF0, 8'h0F});
    chk("R9", underflow_flag, 1, "underflow sticky");

    // R4: zero-length transfer
    clear_logs(); s0 = stop_cnt;
    kick(10'h040, 0, 0, 0, 1); wait_idle("R4");
    expect_wr("R4", '{8'h80});
    chk("R4", stop_cnt - s0, 1, "stop after address only");
    chk("R9", underflow_flag, 0, "underflow cleared by start");
    tick_n(3);

    // R1 R6: foreign master holds the bus
    ext_sda_low = 1; tick_n(5);
    chk("R6", bus_busy, 1, "busy after foreign start");
    clear_logs();
    kick(10'h02A, 0, 0, 1, 1);
    tick_n(50);
    chk("R1", xfer_active, 0, "start refused while busy");
    chk("R1", scl_line, 1, "SCL untouched while refused");
    ext_sda_low = 0; tick_n(5);
    chk("R6", bus_busy, 0, "busy cleared by foreign stop");

    finish_run();
  end
endmodule